// File: doc/BRIEF.md
# Load/Store Queue Ordering Tracker

This block keeps the books on memory operations that a scheduler has sent out but that have not yet finished. It holds one queue for loads and one for stores, and each queue has its own capacity. The scheduler first shows an operation on the dispatch port, where the block answers at once whether that operation fits. If it fits, a valid/ready handshake places it in the queues together with the age tag it carries. The tag grows by one for each new operation and is allowed to wrap. The scheduler can ask at any time whether the operation with a given tag may issue. The block answers from weak-ordering rules that cover loads, stores and the three kinds of barrier. When an operation has executed, the scheduler names its tag on the release port and the block frees its entries.

The dispatch interface is a valid/ready stream. `disp_ready` depends only on the operation being presented and on the current fill of the queues, never on `disp_valid`. An operation is accepted in a cycle where both signals are high. If ready is low, the caller must hold the operation, or withdraw it, until ready rises. `disp_status` explains a stall. Some properties decide where an operation goes. An operation marked as a load uses a load-queue entry. One marked as a store uses a store-queue entry. The side-effect flag turns those entries into barriers. A mode input lets loads go ahead of older stores when the caller knows that they never alias. The tag width must be larger than needed, so that the age span of all live operations stays below half the tag range.

Top module: `lsq_order_tracker`

## Requirements
- R1: `disp_status` reads 0 when the presented operation fits, 1 when it needs a load entry and the load queue is full, and 2 when it needs a store entry and the store queue is full (1 takes precedence). `disp_ready` is high exactly when the status is 0, and a rejected operation takes no entry.
- R2: An operation with neither the load flag nor the store flag reads status 0 and ready high whatever the side flag, and it takes no entry: a query for its tag answers not ready.
- R3: A queue whose capacity parameter is 0 never reports full. Any other queue reports full exactly when its occupancy equals its capacity.
- R4: A load takes one load entry and a store takes one store entry. An operation flagged as both takes one of each.
- R5: The load and side flags together make a load barrier, kept in the load queue only. The store and side flags together make a store barrier, kept in the store queue only. All three flags make a full barrier, which holds one entry in each queue.
- R6: An operation holding a store entry is ready only when no older operation remains in either queue.
- R7: A load that is not a barrier may issue ahead of older loads that are not barriers, but not while an older load barrier remains.
- R8: With `cfg_no_alias` at 0, a load waits until no older store remains. With it at 1, older stores do not hold a load back.
- R9: A load barrier is ready only when it is the oldest entry in the load queue. A store or full barrier must also meet R6.
- R10: A release takes effect at the next rising clock edge. A release for a tag that is not in either queue changes nothing.
- R11: `q_ready` is combinational on `q_tag` and reads 0 for a tag that is not in either queue. Ages are compared modulo the tag range, so a tag that wrapped past zero still counts as younger.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset, empties both queues |
| cfg_no_alias | input | 1 | 1 lets loads go ahead of older stores |
| disp_valid | input | 1 | Dispatch operation valid |
| disp_ready | output | 1 | Dispatch operation can be accepted |
| disp_tag | input | TAG_W | Age tag of the dispatched operation |
| disp_load | input | 1 | Operation may load |
| disp_store | input | 1 | Operation may store |
| disp_side | input | 1 | Operation has side effects (barrier) |
| disp_status | output | 2 | 0 fits, 1 load queue full, 2 store queue full |
| exe_valid | input | 1 | Release request |
| exe_tag | input | TAG_W | Tag of the executed operation |
| q_tag | input | TAG_W | Tag to query |
| q_ready | output | 1 | Queried operation may issue |

## Verification
The hardest case to reach is one where a single age comparison decides the answer while the tags straddle the wrap point. A bench that counts up from zero never produces it. The sweep places every ordered pair of the six operation kinds, in both alias modes, at a rolling base tag that eventually sits at the top of the range, so that the younger tag wraps to zero. In every pair, a release for a tag that is absent is sent before the real releases, so a wrongly matched release would show up in the younger operation's answer.

// File: rtl/lsq_order_pkg.sv
package lsq_order_pkg;
  typedef enum logic [1:0] {
    AV_OK      = 2'd0,
    AV_LQ_FULL = 2'd1,
    AV_SQ_FULL = 2'd2
  } avail_e;
endpackage

// File: rtl/lsq_queue.sv
module lsq_queue #(
  parameter int CAP   = 4,
  parameter int SLOTS = 4,
  parameter int TAG_W = 6
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          alloc_en,
  input  logic [TAG_W-1:0]              alloc_tag,
  input  logic                          alloc_bar,
  input  logic                          rel_en,
  input  logic [TAG_W-1:0]              rel_tag,
  input  logic [TAG_W-1:0]              q_tag,
  output logic                          full,
  output logic [$clog2(SLOTS+1)-1:0]    occ,
  output logic                          q_hit,
  output logic                          q_hit_bar,
  output logic                          q_older_any,
  output logic                          q_older_bar
);
  localparam int CNT_W = $clog2(SLOTS + 1);
  localparam int IDX_W = (SLOTS > 1) ? $clog2(SLOTS) : 1;

  logic [SLOTS-1:0] vld, bar, hit, older;
  logic [TAG_W-1:0] tag [SLOTS];
  logic [IDX_W-1:0] free_idx;
  logic             free_found;

  // lowest free slot
  always_comb begin
    free_idx   = '0;
    free_found = 1'b0;
    for (int i = 0; i < SLOTS; i++) begin
      if (!vld[i] && !free_found) begin
        free_idx   = IDX_W'(i);
        free_found = 1'b1;
      end
    end
  end

  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    logic [TAG_W-1:0] diff;
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        vld[g] <= 1'b0;
        bar[g] <= 1'b0;
        tag[g] <= '0;
      end else begin
        if (rel_en && vld[g] && tag[g] == rel_tag) vld[g] <= 1'b0;
        if (alloc_en && free_found && free_idx == IDX_W'(g)) begin
          vld[g] <= 1'b1;
          bar[g] <= alloc_bar;
          tag[g] <= alloc_tag;
        end
      end
    end
    // modular age: slot is older when (slot - query) is negative
    assign diff     = tag[g] - q_tag;
    assign older[g] = vld[g] && diff[TAG_W-1];
    assign hit[g]   = vld[g] && (tag[g] == q_tag);
  end

  always_comb begin
    occ = '0;
    for (int i = 0; i < SLOTS; i++) occ = occ + CNT_W'(vld[i]);
  end

  assign q_hit       = |hit;
  assign q_hit_bar   = |(hit & bar);
  assign q_older_any = |older;
  assign q_older_bar = |(older & bar);

  if (CAP == 0) begin : g_unbounded
    assign full = 1'b0;
  end else begin : g_bounded
    assign full = (occ == CNT_W'(CAP));
  end
endmodule

// File: rtl/lsq_order_tracker.sv
module lsq_order_tracker
  import lsq_order_pkg::*;
#(
  parameter int TAG_W     = 6,
  parameter int LQ_CAP    = 4,
  parameter int SQ_CAP    = 4,
  parameter int INF_SLOTS = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_no_alias,
  input  logic             disp_valid,
  output logic             disp_ready,
  input  logic [TAG_W-1:0] disp_tag,
  input  logic             disp_load,
  input  logic             disp_store,
  input  logic             disp_side,
  output logic [1:0]       disp_status,
  input  logic             exe_valid,
  input  logic [TAG_W-1:0] exe_tag,
  input  logic [TAG_W-1:0] q_tag,
  output logic             q_ready
);
  localparam int LQ_SLOTS = (LQ_CAP == 0) ? INF_SLOTS : LQ_CAP;
  localparam int SQ_SLOTS = (SQ_CAP == 0) ? INF_SLOTS : SQ_CAP;
  localparam int LQ_CW    = $clog2(LQ_SLOTS + 1);
  localparam int SQ_CW    = $clog2(SQ_SLOTS + 1);

  logic             lq_full, sq_full, accept;
  logic [LQ_CW-1:0] lq_occ;
  logic [SQ_CW-1:0] sq_occ;
  logic lq_hit, lq_hit_bar, lq_older_any, lq_older_bar;
  logic sq_hit, sq_hit_bar, sq_older_any, sq_older_bar;
  logic ld_ok, st_ok;
  avail_e status;

  always_comb begin
    if (disp_load && lq_full)       status = AV_LQ_FULL;
    else if (disp_store && sq_full) status = AV_SQ_FULL;
    else                            status = AV_OK;
  end
  assign disp_status = status;
  assign disp_ready  = (status == AV_OK);
  assign accept      = disp_valid && disp_ready;

  lsq_queue #(.CAP(LQ_CAP), .SLOTS(LQ_SLOTS), .TAG_W(TAG_W)) u_lq (
    .clk, .rst_n,
    .alloc_en(accept && disp_load), .alloc_tag(disp_tag), .alloc_bar(disp_side),
    .rel_en(exe_valid), .rel_tag(exe_tag), .q_tag,
    .full(lq_full), .occ(lq_occ), .q_hit(lq_hit), .q_hit_bar(lq_hit_bar),
    .q_older_any(lq_older_any), .q_older_bar(lq_older_bar)
  );

  lsq_queue #(.CAP(SQ_CAP), .SLOTS(SQ_SLOTS), .TAG_W(TAG_W)) u_sq (
    .clk, .rst_n,
    .alloc_en(accept && disp_store), .alloc_tag(disp_tag), .alloc_bar(disp_side),
    .rel_en(exe_valid), .rel_tag(exe_tag), .q_tag,
    .full(sq_full), .occ(sq_occ), .q_hit(sq_hit), .q_hit_bar(sq_hit_bar),
    .q_older_any(sq_older_any), .q_older_bar(sq_older_bar)
  );

  // store side: nothing older anywhere
  assign st_ok = !sq_older_any && !lq_older_any;
  // load side: barrier must be oldest load; plain load blocked by older
  // load barriers and, unless alias-free, by older stores
  assign ld_ok = lq_hit_bar ? !lq_older_any
                            : (!lq_older_bar && (cfg_no_alias || !sq_older_any));

  assign q_ready = (lq_hit || sq_hit) && (!lq_hit || ld_ok) && (!sq_hit || st_ok);

  logic unused_bar;
  assign unused_bar = sq_hit_bar ^ sq_older_bar;
endmodule

// File: rtl/lsq_order_tracker_chk.sv
module lsq_order_tracker_chk #(
  parameter int TAG_W     = 6,
  parameter int LQ_CAP    = 4,
  parameter int SQ_CAP    = 4,
  parameter int INF_SLOTS = 8
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     disp_valid,
  input logic                     disp_ready,
  input logic                     disp_load,
  input logic                     disp_store,
  input logic [1:0]               disp_status,
  input logic                     exe_valid,
  input logic                     q_ready,
  input logic                     lq_hit,
  input logic                     sq_hit,
  input logic [$clog2(((LQ_CAP == 0) ? INF_SLOTS : LQ_CAP) + 1)-1:0] lq_occ,
  input logic [$clog2(((SQ_CAP == 0) ? INF_SLOTS : SQ_CAP) + 1)-1:0] sq_occ
);
  p_status_legal_r1: assert property (@(posedge clk) disable iff (!rst_n)
    disp_status != 2'd3);

  p_nonmem_avail_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!disp_load && !disp_store) |-> (disp_ready && disp_status == 2'd0));

  p_lq_cap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (LQ_CAP != 0) |-> (lq_occ <= LQ_CAP));

  p_sq_cap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (SQ_CAP != 0) |-> (sq_occ <= SQ_CAP));

  p_load_alloc_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (disp_valid && disp_ready && disp_load && !exe_valid && (LQ_CAP != 0))
      |=> lq_occ == $past(lq_occ) + 1'b1);

  p_store_alloc_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (disp_valid && disp_ready && disp_store && !exe_valid && (SQ_CAP != 0))
      |=> sq_occ == $past(sq_occ) + 1'b1);

  p_release_shrink_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (exe_valid && !(disp_valid && disp_ready))
      |=> (lq_occ <= $past(lq_occ) && sq_occ <= $past(sq_occ)));

  p_query_known_r11: assert property (@(posedge clk) disable iff (!rst_n)
    q_ready |-> (lq_hit || sq_hit));
endmodule

bind lsq_order_tracker lsq_order_tracker_chk #(
  .TAG_W(TAG_W), .LQ_CAP(LQ_CAP), .SQ_CAP(SQ_CAP), .INF_SLOTS(INF_SLOTS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .disp_valid(disp_valid), .disp_ready(disp_ready),
  .disp_load(disp_load), .disp_store(disp_store), .disp_status(disp_status),
  .exe_valid(exe_valid), .q_ready(q_ready), .lq_hit(lq_hit), .sq_hit(sq_hit),
  .lq_occ(lq_occ), .sq_occ(sq_occ)
);

// File: tb/lsq_order_tracker_tb.sv
module lsq_order_tracker_tb;
  localparam int TW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_no_alias = 1'b0;
  logic disp_valid = 1'b0, disp_load = 1'b0, disp_store = 1'b0, disp_side = 1'b0;
  logic [TW-1:0] disp_tag = '0, exe_tag = '0, q_tag = '0;
  logic exe_valid = 1'b0;
  logic disp_ready, q_ready, inf_ready, inf_q_ready;
  logic [1:0] disp_status, inf_status;

  int checks = 0;
  int bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  lsq_order_tracker #(.TAG_W(TW), .LQ_CAP(2), .SQ_CAP(2), .INF_SLOTS(4)) u_dut (
    .clk, .rst_n, .cfg_no_alias, .disp_valid, .disp_ready, .disp_tag,
    .disp_load, .disp_store, .disp_side, .disp_status,
    .exe_valid, .exe_tag, .q_tag, .q_ready);

  lsq_order_tracker #(.TAG_W(TW), .LQ_CAP(0), .SQ_CAP(0), .INF_SLOTS(4)) u_inf (
    .clk, .rst_n, .cfg_no_alias, .disp_valid, .disp_ready(inf_ready), .disp_tag,
    .disp_load, .disp_store, .disp_side, .disp_status(inf_status),
    .exe_valid, .exe_tag, .q_tag, .q_ready(inf_q_ready));

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic present(input int k);
    disp_load  = (k == 0 || k == 2 || k == 4 || k == 5);
    disp_store = (k == 1 || k == 3 || k == 4 || k == 5);
    disp_side  = (k == 2 || k == 3 || k == 4 || k == 6);
  endtask

  // kinds: 0 load,1 store,2 load barrier,3 store barrier,4 full barrier,
  //        5 load+store, 6 side-effect only (non-memory)
  task automatic do_disp(input int k, input int t);
    @(negedge clk);
    present(k);
    disp_tag   = TW'(t);
    disp_valid = 1'b1;
    @(negedge clk);
    disp_valid = 1'b0;
  endtask

  task automatic do_rel(input int t);
    @(negedge clk);
    exe_valid = 1'b1;
    exe_tag   = TW'(t);
    @(negedge clk);
    exe_valid = 1'b0;
  endtask

  task automatic probe(input int k, output int st, output int rd);
    present(k);
    #1;
    st = disp_status;
    rd = disp_ready;
  endtask

  task automatic ask(input int t, output int r);
    q_tag = TW'(t);
    #1;
    r = q_ready;
  endtask

  function automatic int exp_young(input int ko, input int ky, input int na);
    bit ldo = (ko == 0 || ko == 2 || ko == 4 || ko == 5);
    bit sto = (ko == 1 || ko == 3 || ko == 4 || ko == 5);
    bit sdo = (ko == 2 || ko == 3 || ko == 4);
    bit ldy = (ky == 0 || ky == 2 || ky == 4 || ky == 5);
    bit sty = (ky == 1 || ky == 3 || ky == 4 || ky == 5);
    bit sdy = (ky == 2 || ky == 3 || ky == 4);
    int ok = 1;
    if (sty && (ldo || sto)) ok = 0;
    if (ldy) begin
      if (sdy) begin
        if (ldo) ok = 0;
      end else begin
        if (ldo && sdo) ok = 0;
        if (na == 0 && sto) ok = 0;
      end
    end
    return ok;
  endfunction

  initial begin
    repeat (60000) @(posedge clk);
    if (!done) begin
      checks++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end

  initial begin
    int st, rd, r;
    do_reset();
    // reset state
    probe(5, st, rd);
    chk("R1", "reset load+store status", st, 0);
    ask(0, r);
    chk("R11", "reset query empty", r, 0);

    // load queue fill (R1, R3)
    do_disp(0, 0);
    do_disp(0, 1);
    probe(0, st, rd);
    chk("R3", "load status at capacity", st, 1);
    chk("R1", "ready low when full", rd, 0);
    present(0); #1;
    chk("R3", "unbounded load status", inf_status, 0);
    probe(1, st, rd);
    chk("R1", "store status with full LQ", st, 0);
    probe(5, st, rd);
    chk("R1", "load+store precedence", st, 1);
    do_disp(0, 2);
    present(0); #1;
    chk("R3", "unbounded after three loads", inf_status, 0);

    // store queue fill, non-memory, rejection
    do_reset();
    do_disp(1, 0);
    do_disp(1, 1);
    probe(1, st, rd);
    chk("R1", "store status at capacity", st, 2);
    probe(0, st, rd);
    chk("R1", "load status with full SQ", st, 0);
    probe(6, st, rd);
    chk("R2", "non-memory status", st, 0);
    chk("R2", "non-memory ready", rd, 1);
    do_disp(6, 5);
    ask(5, r);
    chk("R2", "non-memory takes no entry", r, 0);
    do_disp(1, 7);
    do_rel(0);
    ask(7, r);
    chk("R1", "rejected store absent", r, 0);
    probe(1, st, rd);
    chk("R3", "store fits after release", st, 0);

    // R4: load+store op occupies both queues
    do_reset();
    do_disp(5, 0);
    probe(0, st, rd);
    chk("R4", "load fits after ld+st", st, 0);
    do_disp(0, 1);
    probe(0, st, rd);
    chk("R4", "LQ full after ld+st and load", st, 1);
    probe(1, st, rd);
    chk("R4", "SQ has room", st, 0);

    // R5: barrier placement
    do_reset();
    do_disp(4, 0);
    do_disp(3, 1);
    probe(1, st, rd);
    chk("R5", "full+store barrier fill SQ", st, 2);
    probe(0, st, rd);
    chk("R5", "LQ holds only full barrier", st, 0);
    do_reset();
    do_disp(2, 0);
    do_disp(2, 1);
    probe(1, st, rd);
    chk("R5", "load barriers skip SQ", st, 0);
    probe(0, st, rd);
    chk("R5", "load barriers fill LQ", st, 1);

    // R10 timing
    do_reset();
    do_disp(1, 0);
    do_disp(1, 1);
    q_tag = TW'(1);
    @(negedge clk);
    exe_valid = 1'b1;
    exe_tag   = TW'(0);
    #1;
    chk("R10", "release not yet visible", q_ready, 0);
    @(negedge clk);
    exe_valid = 1'b0;
    #1;
    chk("R10", "release visible after edge", q_ready, 1);

    // pair sweep
    do_reset();
    for (int na = 0; na < 2; na++) begin
      for (int a = 0; a < 6; a++) begin
        for (int b = 0; b < 6; b++) begin
          int ta, tb, e;
          string req;
          ta = ((na * 36 + a * 6 + b) * 3) % 16;
          tb = (ta + 1) % 16;
          cfg_no_alias = na[0];
          do_disp(a, ta);
          do_disp(b, tb);
          ask(ta, r);
          chk("R9", "oldest op ready", r, 1);
          e = exp_young(a, b, na);
          if (b == 1 || b == 3 || b == 4 || b == 5) req = "R6";
          else if (b == 2) req = "R9";
          else if (na == 1) req = "R8";
          else req = "R7";
          ask(tb, r);
          chk(req, $sformatf("younger k%0d after k%0d na%0d", b, a, na), r, e);
          do_rel((ta + 8) % 16);
          ask(tb, r);
          chk("R10", "absent-tag release ignored", r, e);
          do_rel(ta);
          ask(tb, r);
          chk("R11", "younger alone after wrap-safe release", r, 1);
          ask(ta, r);
          chk("R11", "released tag unknown", r, 0);
          do_rel(tb);
        end
      end
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule